// File: doc/BRIEF.md
# Reconfigurable Byte-Sliced Reload Timer

This block is a 32-bit up-counting timer made of four 8-bit counter slices. A 2-bit grouping field decides at run time whether the slices form one 32-bit timer, two 16-bit timers, four 8-bit timers, or one 16-bit timer with two 8-bit timers beside it. Each slice has its own reload byte and run bit. A global enable gates all of them. Counting advances on a single-cycle tick supplied by an external prescaler.

When a timer group wraps past its all-ones value, every slice in that group loads its own reload byte. The group then raises a one-cycle overflow pulse on the output bit of its most significant slice. An interrupt unit consumes these pulses. Software reaches the count word, the reload word, the run bits, the grouping field and the enable through simple write strobes, and reads them back on registered outputs.

Top module: `rbt_timer`

## Requirements
- R1: After a synchronous reset, the count word, the reload word, the run bits, the grouping field, the enable and all overflow pulses are zero.
- R2: With the enable set and a slice's run bit set, an ungrouped slice advances by one on each cycle in which `tick_i` is high. It holds its value on cycles without a tick.
- R3: While the enable is low, or the run bit of a group's lowest slice is low, the group's count does not change and it produces no overflow pulse.
- R4: Grouping code 2 makes four independent 8-bit timers. A slice that advances from 0xFF loads its own reload byte and pulses its own overflow bit.
- R5: Grouping code 0 chains all four slices into one 32-bit timer. A higher slice advances only on the carry out of the slice below it. Only overflow bit 3 can pulse, and on a wrap all four slices load their reload bytes.
- R6: Grouping code 1 forms two 16-bit timers, slices 1:0 and slices 3:2. Their overflow events appear on bits 1 and 3 respectively, and each wrap reloads only its own pair of slices.
- R7: Grouping code 3 forms a 16-bit timer from slices 3:2 and keeps slices 1 and 0 as separate 8-bit timers. Overflow events appear on bits 3, 1 and 0.
- R8: Within a chained group, only the lowest slice's run bit gates the group. The run bits of the upper slices of that group have no effect.
- R9: A write to the count word takes priority over counting and reloading in the same cycle, and it suppresses any overflow pulse for that cycle.
- R10: Slice i occupies bits 8i+7:8i of both the count word and the reload word, and its overflow event drives `ovf_o[i]`.
- R11: An overflow pulse is registered. It is high for the single cycle that follows the clock edge at which the group loads its reload values, and it is visible together with those loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable pulse from the prescaler |
| cnt_we_i | input | 1 | Count word write strobe |
| cnt_wdata_i | input | 32 | Count word write data |
| rld_we_i | input | 1 | Reload word write strobe |
| rld_wdata_i | input | 32 | Reload word write data |
| ctl_we_i | input | 1 | Control write strobe (run bits, grouping, enable) |
| run_wdata_i | input | 4 | Per-slice run bits to write |
| mode_wdata_i | input | 2 | Grouping code to write |
| en_wdata_i | input | 1 | Global enable to write |
| count_o | output | 32 | Current count word |
| reload_o | output | 32 | Current reload word |
| run_o | output | 4 | Current run bits |
| mode_o | output | 2 | Current grouping code |
| en_o | output | 1 | Current global enable |
| ovf_o | output | 4 | Per-slice overflow pulses |

## Verification
The assertions assume that `tick_i` and the write strobes are synchronous single-cycle levels that are sampled only at the clock edge. The stimulus drives every input on the falling edge and holds it for one full cycle, so this assumption is never violated. The assertions also assume that the reload word does not change on the same edge as a wrap, so the reloaded value can be traced to the previous reload register. The bench never writes the reload word during a tick burst. Grouping changes happen only while no tick is active, which keeps every check of the slice-to-bit mapping tied to a single grouping code.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  localparam int unsigned SLICES = 4;

  typedef enum logic [1:0] {
    GRP_W32     = 2'd0,
    GRP_W16X2   = 2'd1,
    GRP_W8X4    = 2'd2,
    GRP_W16_8X2 = 2'd3
  } grp_mode_e;
endpackage

// File: rtl/rbt_group_map.sv
module rbt_group_map
  import rbt_pkg::*;
(
  input  grp_mode_e         mode_i,
  output logic [SLICES-1:0] link_o,  // slice i takes carry from slice i-1
  output logic [SLICES-1:0] top_o    // slice i is the msb slice of its group
);
  always_comb begin
    link_o = '0;
    unique case (mode_i)
      GRP_W32:     link_o = 4'b1110;
      GRP_W16X2:   link_o = 4'b1010;
      GRP_W8X4:    link_o = 4'b0000;
      GRP_W16_8X2: link_o = 4'b1000;
      default:     link_o = 4'b0000;
    endcase
    for (int i = 0; i < SLICES - 1; i++) top_o[i] = ~link_o[i+1];
    top_o[SLICES-1] = 1'b1;
  end
endmodule

// File: rtl/rbt_carry_net.sv
module rbt_carry_net
  import rbt_pkg::*;
(
  input  logic [SLICES-1:0] base_inc_i,  // tick & enable & own run bit
  input  logic [SLICES-1:0] link_i,
  input  logic [SLICES-1:0] at_max_i,
  output logic [SLICES-1:0] inc_o,
  output logic [SLICES-1:0] carry_o,
  output logic [SLICES-1:0] grp_ovf_o
);
  always_comb begin
    inc_o[0]   = link_i[0] ? 1'b0 : base_inc_i[0];
    carry_o[0] = inc_o[0] & at_max_i[0];
    for (int i = 1; i < SLICES; i++) begin
      inc_o[i]   = link_i[i] ? carry_o[i-1] : base_inc_i[i];
      carry_o[i] = inc_o[i] & at_max_i[i];
    end
    grp_ovf_o[SLICES-1] = carry_o[SLICES-1];
    for (int i = SLICES - 2; i >= 0; i--)
      grp_ovf_o[i] = link_i[i+1] ? grp_ovf_o[i+1] : carry_o[i];
  end
endmodule

// File: rtl/rbt_byte_slice.sv
module rbt_byte_slice #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we_i,
  input  logic [BYTE_W-1:0] load_val_i,
  input  logic              reload_i,
  input  logic [BYTE_W-1:0] reload_val_i,
  input  logic              inc_i,
  output logic [BYTE_W-1:0] cnt_o,
  output logic              at_max_o
);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  always_ff @(posedge clk) begin
    if (rst)            cnt_o <= '0;
    else if (load_we_i) cnt_o <= load_val_i;
    else if (reload_i)  cnt_o <= reload_val_i;
    else if (inc_i)     cnt_o <= cnt_o + ONE;
  end

  assign at_max_o = &cnt_o;

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    load_we_i |=> (cnt_o == $past(load_val_i)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_we_i && !reload_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rbt_timer.sv
module rbt_timer
  import rbt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned TW    = BYTE_W * SLICES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              cnt_we_i,
  input  logic [TW-1:0]     cnt_wdata_i,
  input  logic              rld_we_i,
  input  logic [TW-1:0]     rld_wdata_i,
  input  logic              ctl_we_i,
  input  logic [SLICES-1:0] run_wdata_i,
  input  logic [1:0]        mode_wdata_i,
  input  logic              en_wdata_i,
  output logic [TW-1:0]     count_o,
  output logic [TW-1:0]     reload_o,
  output logic [SLICES-1:0] run_o,
  output logic [1:0]        mode_o,
  output logic              en_o,
  output logic [SLICES-1:0] ovf_o
);
  logic [SLICES-1:0][BYTE_W-1:0] cnt_b, rld_q;
  logic [SLICES-1:0]             run_q, link, top, base_inc, inc, carry, grp_ovf, at_max;
  grp_mode_e                     mode_q;
  logic                          en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q  <= '0;
      run_q  <= '0;
      mode_q <= GRP_W32;
      en_q   <= 1'b0;
      ovf_o  <= '0;
    end else begin
      if (rld_we_i) rld_q <= rld_wdata_i;
      if (ctl_we_i) begin
        run_q  <= run_wdata_i;
        mode_q <= grp_mode_e'(mode_wdata_i);
        en_q   <= en_wdata_i;
      end
      ovf_o <= (carry & top) & {SLICES{~cnt_we_i}};
    end
  end

  assign base_inc = {SLICES{tick_i & en_q}} & run_q;

  rbt_group_map u_map (
    .mode_i (mode_q),
    .link_o (link),
    .top_o  (top)
  );

  rbt_carry_net u_net (
    .base_inc_i (base_inc),
    .link_i     (link),
    .at_max_i   (at_max),
    .inc_o      (inc),
    .carry_o    (carry),
    .grp_ovf_o  (grp_ovf)
  );

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    rbt_byte_slice #(.BYTE_W(BYTE_W)) u_slice (
      .clk          (clk),
      .rst          (rst),
      .load_we_i    (cnt_we_i),
      .load_val_i   (cnt_wdata_i[g*BYTE_W +: BYTE_W]),
      .reload_i     (grp_ovf[g]),
      .reload_val_i (rld_q[g]),
      .inc_i        (inc[g]),
      .cnt_o        (cnt_b[g]),
      .at_max_o     (at_max[g])
    );

    // R11
    ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_o[g] |-> (cnt_b[g] == $past(rld_q[g])));
  end

  assign count_o  = cnt_b;
  assign reload_o = rld_q;
  assign run_o    = run_q;
  assign mode_o   = mode_q;
  assign en_o     = en_q;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_we_i) |=> $stable(count_o));

  // R3
  ovf_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o != '0) |-> $past(en_q && tick_i));

  // R5
  w32_single_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == GRP_W32) |=> (ovf_o[2:0] == 3'b000));

  // R6
  w16_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == GRP_W16X2) |=> (!ovf_o[0] && !ovf_o[2]));

  // R7
  w16_8_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == GRP_W16_8X2) |=> !ovf_o[2]);
endmodule

// File: tb/tb_rbt_timer.sv
module tb_rbt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        cnt_we_i = 1'b0;
  logic [31:0] cnt_wdata_i = '0;
  logic        rld_we_i = 1'b0;
  logic [31:0] rld_wdata_i = '0;
  logic        ctl_we_i = 1'b0;
  logic [3:0]  run_wdata_i = '0;
  logic [1:0]  mode_wdata_i = '0;
  logic        en_wdata_i = 1'b0;
  logic [31:0] count_o, reload_o;
  logic [3:0]  run_o, ovf_o;
  logic [1:0]  mode_o;
  logic        en_o;

  int checks = 0;
  int errors = 0;
  int ovf_cnt [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  rbt_timer dut (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .rld_we_i(rld_we_i), .rld_wdata_i(rld_wdata_i),
    .ctl_we_i(ctl_we_i), .run_wdata_i(run_wdata_i),
    .mode_wdata_i(mode_wdata_i), .en_wdata_i(en_wdata_i),
    .count_o(count_o), .reload_o(reload_o), .run_o(run_o),
    .mode_o(mode_o), .en_o(en_o), .ovf_o(ovf_o)
  );

  always @(negedge clk)
    if (!rst) for (int i = 0; i < 4; i++) ovf_cnt[i] += int'(ovf_o[i]);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic clr_ovf();
    @(negedge clk); #1;
    for (int i = 0; i < 4; i++) ovf_cnt[i] = 0;
  endtask

  function automatic logic [31:0] ovf_hist();
    logic [31:0] v = '0;
    for (int i = 0; i < 4; i++) v[i*8 +: 8] = 8'(ovf_cnt[i]);
    return v;
  endfunction

  task automatic set_ctl(bit en, logic [3:0] run, logic [1:0] mode);
    @(negedge clk);
    ctl_we_i = 1; en_wdata_i = en; run_wdata_i = run; mode_wdata_i = mode;
    @(negedge clk);
    ctl_we_i = 0;
  endtask

  task automatic wr_cnt(logic [31:0] v);
    @(negedge clk); cnt_we_i = 1; cnt_wdata_i = v;
    @(negedge clk); cnt_we_i = 0;
  endtask

  task automatic wr_rld(logic [31:0] v);
    @(negedge clk); rld_we_i = 1; rld_wdata_i = v;
    @(negedge clk); rld_we_i = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1;
    end
    @(negedge clk); tick_i = 0;
    #1;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R1 count", count_o, 32'h0);
    check("R1 reload", reload_o, 32'h0);
    check("R1 ctl", {25'd0, en_o, mode_o, run_o}, 32'h0);
    check("R1 ovf", {28'd0, ovf_o}, 32'h0);
  endtask

  task automatic t_eight_bit();
    set_ctl(1, 4'hF, 2'd2);
    wr_rld(32'h40302010);
    check("R10 reload layout", reload_o, 32'h40302010);
    wr_cnt(32'h01FDFE10);
    clr_ovf();
    ticks(3);
    check("R4 count after 3 ticks", count_o, 32'h04302113);
    check("R4 ovf history", ovf_hist(), 32'h00010100);
    check("R11 ovf visible with reload", {28'd0, ovf_o}, 32'h4);
    repeat (5) @(negedge clk);
    #1;
    check("R2 hold without tick", count_o, 32'h04302113);
  endtask

  task automatic t_gating();
    set_ctl(0, 4'hF, 2'd2);
    clr_ovf();
    ticks(4);
    check("R3 enable low holds", count_o, 32'h04302113);
    check("R3 enable low no ovf", ovf_hist(), 32'h0);
    set_ctl(1, 4'hE, 2'd2);
    ticks(2);
    check("R2 R3 run bit gates slice0", count_o, 32'h06322313);
  endtask

  task automatic t_w32();
    set_ctl(1, 4'h1, 2'd0);
    wr_rld(32'h11223344);
    wr_cnt(32'h000000FF);
    ticks(1);
    check("R5 carry into slice1", count_o, 32'h00000100);
    wr_cnt(32'hFFFFFFFE);
    clr_ovf();
    ticks(2);
    check("R5 R8 32-bit wrap reloads all", count_o, 32'h11223344);
    check("R5 only ovf bit 3", ovf_hist(), 32'h01000000);
    check("R11 ovf pulse bit 3", {28'd0, ovf_o}, 32'h8);
    set_ctl(1, 4'hE, 2'd0);
    ticks(3);
    check("R8 lowest run bit off stops group", count_o, 32'h11223344);
  endtask

  task automatic t_w16();
    set_ctl(1, 4'hF, 2'd1);
    wr_rld(32'h01020304);
    wr_cnt(32'h7FFFFFFF);
    clr_ovf();
    ticks(1);
    check("R6 low pair wraps", count_o, 32'h80000304);
    check("R6 ovf bit 1", {28'd0, ovf_o}, 32'h2);
    wr_cnt(32'hFFFF0000);
    ticks(1);
    check("R6 high pair wraps", count_o, 32'h01020001);
    check("R6 ovf bit 3", {28'd0, ovf_o}, 32'h8);
  endtask

  task automatic t_mixed();
    set_ctl(1, 4'hF, 2'd3);
    wr_rld(32'h0A0B0C0D);
    wr_cnt(32'h12FFFFFF);
    ticks(1);
    check("R7 bytes wrap, pair carries", count_o, 32'h13000C0D);
    check("R7 ovf bits 1 and 0", {28'd0, ovf_o}, 32'h3);
    wr_cnt(32'hFFFF0505);
    ticks(1);
    check("R7 pair wraps", count_o, 32'h0A0B0606);
    check("R7 ovf bit 3", {28'd0, ovf_o}, 32'h8);
  endtask

  task automatic t_write_prio();
    set_ctl(1, 4'hF, 2'd2);
    wr_rld(32'h00000077);
    wr_cnt(32'h000000FF);
    clr_ovf();
    @(negedge clk);
    tick_i = 1; cnt_we_i = 1; cnt_wdata_i = 32'h00000055;
    @(negedge clk);
    tick_i = 0; cnt_we_i = 0;
    #1;
    check("R9 write beats count", count_o, 32'h00000055);
    check("R9 no ovf on write", ovf_hist(), 32'h0);
    ticks(1);
    check("R2 count resumes", count_o, 32'h01010156);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) ovf_cnt[i] = 0;
    t_reset();
    t_eight_bit();
    t_gating();
    t_w32();
    t_w16();
    t_mixed();
    t_write_prio();
    finish_run();
  end
endmodule